// File: doc/BRIEF.md
# DRAM Refresh and Self-Refresh Scheduler

This block keeps a 2048-row asynchronous DRAM alive. It shares the control pins with an access sequencer through a request/grant handshake. It drives the row strobe, column strobe and write enable only while the grant is held; at all other times those pins sit at their idle level and the drive qualifier is low. After reset it waits out the power-up pause and then runs a fixed number of warm-up refreshes before it raises `ready`.

In normal operation an interval timer fires once per distributed refresh period. Each firing adds one refresh to an owed counter, so a refresh that falls due while the sequencer keeps the pins is postponed rather than lost. Each refresh is a column-before-row cycle unless the row-address mode is selected. In that mode the column strobe stays idle and an internal row counter is placed on the address pins, advancing after every refresh.

A sleep request is handled as one bracket that keeps the grant throughout. The bracket runs one column-before-row refresh, then self refresh held for at least the minimum long-strobe time, then the extended precharge, then a second refresh. After the bracket the interval timer restarts. All timing is given in nanoseconds and converted to clock cycles from a clock-period parameter.

Top module: `dram_refresh_mgr`

## Requirements
- R1: After reset release, `ref_req` stays low for at least C_INIT = ceil(T_INIT_NS/CLK_NS) cycles. Exactly WARM_N refresh cycles (falling edges of `ras_n`) then occur, after which `ready` goes high and stays high.
- R2: Take the case where the grant is returned at a fixed latency and the refresh type does not change. Consecutive refreshes then have their `ras_n` falling edges exactly C_REFI = floor(T_REFI_NS/CLK_NS) cycles apart.
- R3: In a column-before-row cycle (`cas_n` low when `ras_n` falls), `cas_n` has been low for at least C_SETUP cycles and `we_n` is high when `ras_n` falls. `cas_n` stays low for as long as `ras_n` is low.
- R4: Every low pulse on `ras_n` lasts at least C_ACT = ceil(max(T_RAS_NS,T_CHR_NS)/CLK_NS) cycles. The high time before any falling edge is at least C_RP cycles.
- R5: When `sleep_req` is seen while idle, one column-before-row refresh runs first. Then `cas_n` goes low before `ras_n`, and both stay low with `sr_active` high. This lasts until `sleep_req` is low and at least C_SRMIN = T_SR_NS/CLK_NS + 1 cycles have passed.
- R6: On leaving self refresh, `ras_n` stays high for at least C_RPS cycles and then for no more than C_RPS + 4 cycles. A column-before-row refresh follows before `ref_req` is released.
- R7: With `mode_ras_only` = 1 sampled at grant, a refresh keeps `cas_n` high. During that refresh `addr` carries the row counter, which starts at 0 after reset and advances by one after each such refresh.
- R8: Suppose N interval periods end while the grant is withheld, with N <= OWE_MAX. Then exactly N refreshes run back to back once the grant returns.
- R9: While `ref_gnt` is low, `ras_n` and `cas_n` are high and `drive_en` is low. Once raised, `ref_req` stays high until granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_req | input | 1 | Request to enter and hold self refresh |
| mode_ras_only | input | 1 | 1 selects row-address refresh, 0 column-before-row |
| ref_gnt | input | 1 | Grant of the DRAM control pins from the sequencer |
| ref_req | output | 1 | Request for the DRAM control pins |
| ready | output | 1 | Power-up and warm-up complete |
| sr_active | output | 1 | Self-refresh bracket in progress |
| drive_en | output | 1 | This block is driving the DRAM pins |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high (inactive) |
| addr | output | ROW_BITS | Refresh row address in row-address mode, else 0 |

## Verification
A corrupted interval timer or owed counter shows at the ports within one refresh period. It appears as a falling-edge spacing other than C_REFI, or as the wrong number of back-to-back refreshes after a withheld grant. A sequencer in the wrong phase shows on the very next strobe edge: a row strobe without the column lead, a pulse that is too short, or a precharge that is too short. A stale row counter shows at the next row-address refresh, and a broken self-refresh bracket shows when the sleep request drops.

// File: rtl/refmgr_pkg.sv
package refmgr_pkg;

   typedef enum logic [3:0] {
      ST_INIT, ST_IDLE, ST_REQ, ST_SETUP, ST_ACT, ST_PRE,
      ST_SRSET, ST_SRHOLD, ST_SRPRE
   } rm_state_e;

   typedef enum logic [1:0] {
      JOB_WARM, JOB_NORM, JOB_PRESR, JOB_POSTSR
   } rm_job_e;

   // Round a time up to whole clock cycles, never below one.
   function automatic int ns2cyc(input int ns, input int clk_ns);
      int c;
      c = (ns + clk_ns - 1) / clk_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/refmgr_ivl_timer.sv
module refmgr_ivl_timer #(
   parameter int C_REFI  = 1560,
   parameter int OWE_MAX = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   input  logic take,
   output logic owed_nz
);
   localparam int TW = $clog2(C_REFI);
   localparam int OW = $clog2(OWE_MAX + 1);

   logic [TW-1:0] tcnt;
   logic [OW-1:0] owed;
   logic          tick;

   assign tick    = run && (tcnt == TW'(C_REFI - 1));
   assign owed_nz = (owed != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tcnt <= '0;
         owed <= '0;
      end else if (clear) begin
         tcnt <= '0;
         owed <= '0;
      end else begin
         if (run) tcnt <= tick ? '0 : tcnt + 1'b1;
         case ({tick, take})
            2'b10:   if (owed != OW'(OWE_MAX)) owed <= owed + 1'b1;
            2'b01:   if (owed != '0) owed <= owed - 1'b1;
            default: owed <= owed;
         endcase
      end
   end
endmodule

// File: rtl/refmgr_rowctr.sv
module refmgr_rowctr #(
   parameter int ROW_BITS = 11
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                inc,
   output logic [ROW_BITS-1:0] row
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   row <= '0;
      else if (inc) row <= row + 1'b1;
   end
endmodule

// File: rtl/refmgr_seq.sv
module refmgr_seq import refmgr_pkg::*; #(
   parameter int C_INIT  = 20000,
   parameter int C_SETUP = 1,
   parameter int C_ACT   = 6,
   parameter int C_RP    = 4,
   parameter int C_RPS   = 11,
   parameter int C_SRMIN = 10001,
   parameter int WARM_N  = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic mode_ras_only,
   input  logic ref_gnt,
   input  logic owed_nz,
   output logic ref_req,
   output logic ready,
   output logic sr_active,
   output logic drive_en,
   output logic ras_n,
   output logic cas_n,
   output logic use_row,
   output logic take,
   output logic tmr_run,
   output logic tmr_clear,
   output logic row_inc
);
   localparam int C_MAXC = imax(imax(C_INIT, C_SRMIN), imax(imax(C_RPS, C_ACT), imax(C_RP, C_SETUP)));
   localparam int CW     = $clog2(C_MAXC + 1);
   localparam int WW     = $clog2(WARM_N + 1);

   rm_state_e       state;
   rm_job_e         job;
   logic [CW-1:0]   cnt;
   logic [WW-1:0]   warm;
   logic            rao;
   logic            ready_q;
   logic            held;
   logic            ras_low;
   logic            cas_low;
   logic            in_bracket;
   logic            pick_rao;

   assign pick_rao = mode_ras_only && (job == JOB_WARM || job == JOB_NORM);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_INIT;
         job     <= JOB_WARM;
         cnt     <= '0;
         warm    <= '0;
         rao     <= 1'b0;
         ready_q <= 1'b0;
      end else begin
         case (state)
            ST_INIT: begin
               if (cnt == CW'(C_INIT - 1)) begin
                  cnt   <= '0;
                  job   <= JOB_WARM;
                  state <= ST_REQ;
               end else cnt <= cnt + 1'b1;
            end
            ST_IDLE: begin
               if (sleep_req) begin
                  job   <= JOB_PRESR;
                  state <= ST_REQ;
               end else if (owed_nz) begin
                  job   <= JOB_NORM;
                  state <= ST_REQ;
               end
            end
            ST_REQ: begin
               if (ref_gnt) begin
                  cnt   <= '0;
                  rao   <= pick_rao;
                  state <= pick_rao ? ST_ACT : ST_SETUP;
               end
            end
            ST_SETUP: begin
               if (cnt == CW'(C_SETUP - 1)) begin
                  cnt   <= '0;
                  state <= ST_ACT;
               end else cnt <= cnt + 1'b1;
            end
            ST_ACT: begin
               if (cnt == CW'(C_ACT - 1)) begin
                  cnt   <= '0;
                  state <= ST_PRE;
               end else cnt <= cnt + 1'b1;
            end
            ST_PRE: begin
               if (cnt == CW'(C_RP - 1)) begin
                  cnt <= '0;
                  case (job)
                     JOB_WARM: begin
                        if (warm == WW'(WARM_N - 1)) begin
                           ready_q <= 1'b1;
                           state   <= ST_IDLE;
                        end else begin
                           warm  <= warm + 1'b1;
                           state <= ST_REQ;
                        end
                     end
                     JOB_PRESR: state <= ST_SRSET;
                     default:   state <= ST_IDLE;
                  endcase
               end else cnt <= cnt + 1'b1;
            end
            ST_SRSET: begin
               if (cnt == CW'(C_SETUP - 1)) begin
                  cnt   <= '0;
                  state <= ST_SRHOLD;
               end else cnt <= cnt + 1'b1;
            end
            ST_SRHOLD: begin
               if (cnt == CW'(C_SRMIN - 1)) begin
                  if (!sleep_req) begin
                     cnt   <= '0;
                     state <= ST_SRPRE;
                  end
               end else cnt <= cnt + 1'b1;
            end
            ST_SRPRE: begin
               if (cnt == CW'(C_RPS - 1)) begin
                  cnt   <= '0;
                  job   <= JOB_POSTSR;
                  state <= ST_REQ;
               end else cnt <= cnt + 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign ref_req    = (state != ST_INIT) && (state != ST_IDLE);
   assign held       = ref_req && ref_gnt && (state != ST_REQ);
   assign ras_low    = (state == ST_ACT) || (state == ST_SRHOLD);
   assign cas_low    = (state == ST_SETUP) || (state == ST_SRSET) || (state == ST_SRHOLD)
                       || ((state == ST_ACT) && !rao);
   assign ras_n      = !(held && ras_low);
   assign cas_n      = !(held && cas_low);
   assign drive_en   = held;
   assign use_row    = held && rao && (state == ST_ACT);
   assign ready      = ready_q;
   assign sr_active  = (state == ST_SRSET) || (state == ST_SRHOLD) || (state == ST_SRPRE);
   assign in_bracket = (job == JOB_PRESR || job == JOB_POSTSR) && (state != ST_IDLE);
   assign tmr_run    = ready_q && !in_bracket;
   assign take       = (state == ST_REQ) && ref_gnt && (job == JOB_NORM || job == JOB_PRESR);
   assign tmr_clear  = (state == ST_PRE) && (job == JOB_POSTSR) && (cnt == CW'(C_RP - 1));
   assign row_inc    = (state == ST_ACT) && rao && (cnt == CW'(C_ACT - 1));
endmodule

// File: rtl/dram_refresh_mgr.sv
module dram_refresh_mgr import refmgr_pkg::*; #(
   parameter int CLK_NS      = 10,
   parameter int ROW_BITS    = 11,
   parameter int WARM_N      = 8,
   parameter int OWE_MAX     = 8,
   parameter int T_INIT_NS   = 200000,
   parameter int T_REFI_NS   = 15600,
   parameter int T_CSR_NS    = 5,
   parameter int T_WRP_NS    = 10,
   parameter int T_CHR_NS    = 10,
   parameter int T_RAS_NS    = 60,
   parameter int T_RP_NS     = 40,
   parameter int T_RPS_NS    = 110,
   parameter int T_SR_NS     = 100000,
   parameter bit RAS_ONLY_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sleep_req,
   input  logic                mode_ras_only,
   input  logic                ref_gnt,
   output logic                ref_req,
   output logic                ready,
   output logic                sr_active,
   output logic                drive_en,
   output logic                ras_n,
   output logic                cas_n,
   output logic                we_n,
   output logic [ROW_BITS-1:0] addr
);
   localparam int C_INIT  = ns2cyc(T_INIT_NS, CLK_NS);
   localparam int C_REFI  = T_REFI_NS / CLK_NS;
   localparam int C_SETUP = ns2cyc(imax(T_CSR_NS, T_WRP_NS), CLK_NS);
   localparam int C_ACT   = ns2cyc(imax(T_RAS_NS, T_CHR_NS), CLK_NS);
   localparam int C_RP    = ns2cyc(T_RP_NS, CLK_NS);
   localparam int C_RPS   = ns2cyc(T_RPS_NS, CLK_NS);
   localparam int C_SRMIN = T_SR_NS / CLK_NS + 1;

   if (CLK_NS < 1 || ROW_BITS < 1 || WARM_N < 1 || OWE_MAX < 1) begin : g_bad_cfg
      $error("dram_refresh_mgr: non-positive configuration parameter");
   end
   if (C_REFI < C_SETUP + C_ACT + C_RP + 4) begin : g_bad_ivl
      $error("dram_refresh_mgr: refresh interval shorter than one refresh cycle");
   end

   logic owed_nz, take, tmr_run, tmr_clear, row_inc, use_row, mode_eff;

   refmgr_ivl_timer #(
      .C_REFI (C_REFI),
      .OWE_MAX(OWE_MAX)
   ) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (tmr_run),
      .clear  (tmr_clear),
      .take   (take),
      .owed_nz(owed_nz)
   );

   refmgr_seq #(
      .C_INIT (C_INIT),
      .C_SETUP(C_SETUP),
      .C_ACT  (C_ACT),
      .C_RP   (C_RP),
      .C_RPS  (C_RPS),
      .C_SRMIN(C_SRMIN),
      .WARM_N (WARM_N)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .sleep_req    (sleep_req),
      .mode_ras_only(mode_eff),
      .ref_gnt      (ref_gnt),
      .owed_nz      (owed_nz),
      .ref_req      (ref_req),
      .ready        (ready),
      .sr_active    (sr_active),
      .drive_en     (drive_en),
      .ras_n        (ras_n),
      .cas_n        (cas_n),
      .use_row      (use_row),
      .take         (take),
      .tmr_run      (tmr_run),
      .tmr_clear    (tmr_clear),
      .row_inc      (row_inc)
   );

   if (RAS_ONLY_EN) begin : g_row
      logic [ROW_BITS-1:0] row_q;
      refmgr_rowctr #(.ROW_BITS(ROW_BITS)) u_row (
         .clk  (clk),
         .rst_n(rst_n),
         .inc  (row_inc),
         .row  (row_q)
      );
      assign mode_eff = mode_ras_only;
      assign addr     = use_row ? row_q : '0;
   end else begin : g_norow
      assign mode_eff = 1'b0;
      assign addr     = '0;
   end

   assign we_n = 1'b1;
endmodule

// File: rtl/refmgr_chk.sv
module refmgr_chk #(
   parameter int ROW_BITS = 11,
   parameter int C_RP     = 4,
   parameter int C_ACT    = 6
) (
   input logic                clk,
   input logic                rst_n,
   input logic                ref_req,
   input logic                ref_gnt,
   input logic                ready,
   input logic                sr_active,
   input logic                drive_en,
   input logic                ras_n,
   input logic                cas_n,
   input logic [ROW_BITS-1:0] addr
);
   int hi_run;
   int lo_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_run <= C_RP;
         lo_run <= 0;
      end else begin
         hi_run <= ras_n  ? ((hi_run < C_RP)  ? hi_run + 1 : hi_run) : 0;
         lo_run <= !ras_n ? ((lo_run < C_ACT) ? lo_run + 1 : lo_run) : 0;
      end
   end

   // R3: column strobe leads the row strobe in a column-before-row cycle
   a_r3_cas_leads_ras: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(ras_n) && !cas_n) |-> !$past(cas_n));
   // R3: column strobe held while the row strobe is low
   a_r3_cas_held: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && $past(!ras_n) && $past(!cas_n)) |-> !cas_n);
   a_r4_precharge: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (hi_run >= C_RP));
   a_r4_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ras_n) |-> (lo_run >= C_ACT));
   a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ras_n && cas_n && $past(!ras_n)) |-> $stable(addr));
   a_r9_idle_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_gnt |-> (ras_n && cas_n && !drive_en));
   a_r9_req_until_gnt: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_req && !ref_gnt) |=> ref_req);
   a_r1_ready_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);
   a_r5_sr_holds_req: assert property (@(posedge clk) disable iff (!rst_n)
      sr_active |-> ref_req);
endmodule

bind dram_refresh_mgr refmgr_chk #(
   .ROW_BITS(ROW_BITS),
   .C_RP    (C_RP),
   .C_ACT   (C_ACT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ref_req  (ref_req),
   .ref_gnt  (ref_gnt),
   .ready    (ready),
   .sr_active(sr_active),
   .drive_en (drive_en),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .addr     (addr)
);

// File: tb/sim_dram_refresh_mgr.sv
module sim_dram_refresh_mgr;
   localparam int CLK_NS  = 10;
   localparam int C_INIT  = 200000 / CLK_NS;
   localparam int C_REFI  = 15600 / CLK_NS;
   localparam int C_SETUP = 1;
   localparam int C_RAS   = 6;
   localparam int C_RP    = 4;
   localparam int C_RPS   = 11;
   localparam int C_SRMIN = 100000 / CLK_NS + 1;
   localparam int WARM_N  = 8;
   localparam int ROWS    = 2048;
   localparam int WD      = 190000;

   logic clk = 1'b0, rst_n = 1'b0, sleep_req = 1'b0, mode_ras_only = 1'b0, ref_gnt = 1'b0;
   logic ref_req, ready, sr_active, drive_en, ras_n, cas_n, we_n;
   logic [10:0] addr;

   always #(CLK_NS / 2) clk = ~clk;

   dram_refresh_mgr u0 (
      .clk(clk), .rst_n(rst_n), .sleep_req(sleep_req), .mode_ras_only(mode_ras_only),
      .ref_gnt(ref_gnt), .ref_req(ref_req), .ready(ready), .sr_active(sr_active),
      .drive_en(drive_en), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .addr(addr)
   );

   int nchk = 0, nerr = 0, cyc = 0;
   bit done = 0;
   bit block = 0;
   int lat = 0, wcnt = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic finish_run();
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   endtask

   always @(posedge clk) cyc <= cyc + 1;

   // sequencer model: grants after lat negedges, withholds while block is set
   always @(negedge clk) begin
      if (!rst_n || block) begin
         ref_gnt <= 1'b0;
         wcnt    <= 0;
      end else if (ref_req) begin
         if (wcnt >= lat) ref_gnt <= 1'b1;
         else wcnt <= wcnt + 1;
      end else begin
         ref_gnt <= 1'b0;
         wcnt    <= 0;
      end
   end

   // pin monitor
   logic pr = 1'b1, pc = 1'b1;
   int n_fall = 0, n_cbr = 0, n_ro = 0, n_ivl = 0;
   int fall_t = 0, rise_t = -100, cas_fall_t = 0, last_low = 0, long_low = 0, prev_t = 0;
   int exp_row = 0;
   bit cbr_cur = 0, cas_broke = 0, ivl_on = 0, ivl_prev = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (pc && !cas_n) cas_fall_t = cyc;
         if (pr && !ras_n) begin
            n_fall++;
            if (last_low >= C_SRMIN) begin
               chk(cyc - rise_t >= C_RPS, "R6 long precharge", cyc - rise_t, C_RPS);
               chk(cyc - rise_t <= C_RPS + 4 && !cas_n, "R6 refresh after exit", cyc - rise_t, C_RPS + 4);
            end else begin
               chk(cyc - rise_t >= C_RP, "R4 precharge", cyc - rise_t, C_RP);
            end
            if (!cas_n) begin
               cbr_cur = 1;
               n_cbr++;
               chk(cyc - cas_fall_t >= C_SETUP, "R3 cas lead", cyc - cas_fall_t, C_SETUP);
               chk(we_n == 1'b1, "R3 we high", we_n, 1);
            end else begin
               cbr_cur = 0;
               n_ro++;
               chk(addr == 11'(exp_row), "R7 row address", addr, exp_row);
               exp_row = (exp_row + 1) % ROWS;
            end
            if (ivl_on) begin
               if (ivl_prev) begin
                  chk(cyc - prev_t == C_REFI, "R2 interval", cyc - prev_t, C_REFI);
                  n_ivl++;
               end
               ivl_prev = 1;
               prev_t = cyc;
            end
            fall_t = cyc;
            cas_broke = 0;
         end else if (!pr && ras_n) begin
            last_low = cyc - fall_t;
            chk(last_low >= C_RAS, "R4 pulse width", last_low, C_RAS);
            chk(!cas_broke, cbr_cur ? "R3 cas held" : "R7 cas idle", cas_broke, 0);
            if (last_low > 1000) long_low = last_low;
            rise_t = cyc;
         end else if (!ras_n) begin
            if (cbr_cur == cas_n) cas_broke = 1;
         end
      end
      pr = ras_n;
      pc = cas_n;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         nerr++;
         nchk++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD);
         finish_run();
      end
   end

   initial begin
      int t_rel, f0, f1;
      void'($urandom(32'h1d5e_a7c3));
      repeat (5) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_rel = cyc;
      @(negedge clk);
      chk(!ready && !ref_req, "R1 reset state", {ready, ref_req}, 0);
      chk(ras_n && cas_n && !drive_en, "R9 idle pins", {ras_n, cas_n, drive_en}, 3'b110);

      // R1: power-up pause and warm-up count
      while (!ref_req) @(negedge clk);
      chk(cyc - t_rel >= C_INIT, "R1 init pause", cyc - t_rel, C_INIT);
      while (!ready) @(negedge clk);
      chk(n_fall == WARM_N, "R1 warm-up count", n_fall, WARM_N);
      chk(n_cbr == WARM_N, "R1 warm-up type", n_cbr, WARM_N);

      // R2: fixed-latency interval
      ivl_prev = 0;
      ivl_on = 1;
      repeat (5 * C_REFI + 50) @(negedge clk);
      ivl_on = 0;
      chk(n_ivl >= 4, "R2 interval samples", n_ivl, 4);

      // R8/R9: withhold grant over three periods
      f0 = n_fall;
      while (n_fall == f0) @(negedge clk);
      while (ref_req) @(negedge clk);
      block = 1;
      f1 = n_fall;
      repeat (3 * C_REFI + C_REFI / 2) @(negedge clk);
      chk(n_fall == f1, "R9 no strobe without grant", n_fall - f1, 0);
      chk(ref_req == 1'b1, "R9 request pending", ref_req, 1);
      block = 0;
      repeat (200) @(negedge clk);
      chk(n_fall - f1 == 3, "R8 owed refreshes", n_fall - f1, 3);

      // R7: row-address refresh
      while (ref_req) @(negedge clk);
      mode_ras_only = 1'b1;
      f0 = n_ro;
      ivl_prev = 0;
      ivl_on = 1;
      repeat (4 * C_REFI + 50) @(negedge clk);
      ivl_on = 0;
      chk(n_ro - f0 >= 4, "R7 row refresh count", n_ro - f0, 4);
      while (ref_req) @(negedge clk);
      mode_ras_only = 1'b0;

      // R5/R6: long sleep
      f0 = n_fall;
      sleep_req = 1'b1;
      while (!sr_active) @(negedge clk);
      chk(n_fall == f0 + 1, "R5 refresh before sleep", n_fall - f0, 1);
      repeat (12000) @(negedge clk);
      chk(!ras_n && !cas_n && sr_active, "R5 self refresh held", {ras_n, cas_n, sr_active}, 3'b001);
      sleep_req = 1'b0;
      while (sr_active || ref_req) @(negedge clk);
      chk(n_fall == f0 + 3, "R6 refresh after sleep", n_fall - f0, 3);
      chk(long_low >= 12000, "R5 long hold", long_low, 12000);

      // R5: short sleep request still gets the minimum hold
      long_low = 0;
      f0 = n_fall;
      sleep_req = 1'b1;
      while (!sr_active) @(negedge clk);
      repeat (20) @(negedge clk);
      sleep_req = 1'b0;
      while (sr_active || ref_req) @(negedge clk);
      chk(long_low >= C_SRMIN, "R5 minimum hold", long_low, C_SRMIN);
      chk(n_fall == f0 + 3, "R6 bracket refreshes", n_fall - f0, 3);

      // random latency and mode
      f0 = n_fall;
      for (int i = 0; i < 8 * C_REFI; i++) begin
         @(negedge clk);
         if (!ref_req) lat = $urandom_range(6, 0);
         if ($urandom_range(99, 0) == 0) mode_ras_only = ~mode_ras_only;
      end
      chk(n_fall - f0 >= 7, "R2 refresh rate under random grant", n_fall - f0, 7);
      finish_run();
   end
endmodule